// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block holds eight 32-bit counters that each count one event line picked from a 31-wide event vector. Software configures and reads the bank through a small register port. Each counter has a count register, a configuration register and, for the timer counters, a threshold register.

Any even counter can be joined with the odd counter above it to make a single 64-bit count. The odd word then advances only when the even word rolls over. Counters 2 and 4 keep a shadow copy of their partner's high word. Software reads the low word first, then the high word, and gets a coherent 64-bit pair even when a rollover happens between the two reads.

Counters 0 and 1 also act as timers. When a count first reaches its programmed threshold, the block raises an active-high interrupt pulse two clocks long.

Top module: `evt_ctr_bank`

## Requirements
- R1: After a synchronous active-low reset, every count reads 0, every configuration register reads 0, both thresholds read 0xFFFFFFFF, the read data is 0 and both interrupts are low.
- R2: The register address is {kind[1:0], index[2:0]}. Kind 0 selects a count, kind 1 a configuration and kind 2 a threshold; kind 3 reads 0. Read data appears on the clock after the read strobe and holds until the next read. The configuration word is: bit 0 enable, bits 5:1 event select, bit 8 chain.
- R3: An enabled counter that is not the high word of a chain adds one on every clock in which its selected event line is high. A select of 31 or a cleared enable stops it.
- R4: A write to a count register loads the written value, even if an increment would have happened in that cycle.
- R5: When bit 8 is set in an even counter's configuration, the odd counter above it adds one only on the cycle the even counter rolls over from 0xFFFFFFFF to 0. The odd counter's own enable and select are then ignored. Bit 8 of an odd counter's configuration always reads 0.
- R6: For the chained pairs 2/3 and 4/5, a read of the low word captures the high word into a shadow register, and a read of the high word returns that shadow value.
- R7: For the chained pairs 0/1 and 6/7, a read of the high word returns its current value.
- R8: Counters 0 and 1 have thresholds. When the count first equals the threshold, the matching interrupt goes high on the next clock and stays high for exactly 2 clocks.
- R9: A count that stays equal to its threshold raises no further pulse. A new match during a pulse restarts the 2-clock pulse.
- R10: Threshold addresses of counters 2 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address {kind, index} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after reg_rd |
| evt_in | input | 31 | Event lines |
| tmr_irq | output | 2 | Timer interrupts for counters 0 and 1 |

## Verification
The embedded assertions check the following on every clock:
- write priority and single-step counting in each counter cell;
- the high word of a chain changing only after a low-word rollover or a direct write;
- an interrupt starting right after a match and never rising without one.

The bench covers what needs a chosen sequence of operations:
- shadow coherence across a rollover between the low-word and high-word reads;
- live reads on the pairs without a shadow;
- the exact 2-clock pulse length;
- no re-triggering while the count stays equal, and the restart on a second match;
- threshold writes ignored on counters without a timer.

A behavioural model compares read data and interrupts on every clock.

// File: rtl/evt_ctr_pkg.sv
// Package: shared types for the event counter bank.
// Assumes event selects fit in EVT_SEL_W bits.
package evt_ctr_pkg;
    localparam int EVT_SEL_W = 5;

    typedef struct packed {
        logic                 chain;
        logic [EVT_SEL_W-1:0] sel;
        logic                 en;
    } ctr_cfg_t;

    typedef enum logic [1:0] {
        K_COUNT = 2'd0,
        K_CFG   = 2'd1,
        K_THR   = 2'd2,
        K_NONE  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/evt_ctr_cell.sv
// One counter: holds its count and configuration, and steps on its selected
// event or, as the high word of a chain, on the carry from below.
// Assumes CTR_W >= 9 so that the configuration word fits in the write data.
module evt_ctr_cell import evt_ctr_pkg::*; #(
    parameter int CTR_W     = 32,
    parameter int NUM_EVT   = 31,
    parameter bit CAN_CHAIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             cfg_we,
    input  logic [CTR_W-1:0] wdata,
    input  logic [NUM_EVT-1:0] evt,
    input  logic             use_carry,
    input  logic             carry_in,
    output logic [CTR_W-1:0] count,
    output ctr_cfg_t         cfg,
    output logic             wrap
);
    localparam int PAD_W = 1 << EVT_SEL_W;

    logic [PAD_W-1:0] evt_pad;
    logic             step;

    assign evt_pad = PAD_W'(evt);

    // Pick the step source: carry from below when chained, else the selected event.
    always_comb begin
        if (use_carry) step = carry_in;
        else           step = cfg.en && (32'(cfg.sel) < NUM_EVT) && evt_pad[cfg.sel];
    end

    // A rollover that really happens (not overridden by a write) feeds the pair.
    assign wrap = step && (&count) && !cnt_we;

    // Count register: a write wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_we) count <= wdata;
        else if (step)   count <= count + 1'b1;
    end

    // Configuration register; the chain bit exists only where a pair is possible.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_we) cfg <= '{chain: CAN_CHAIN ? wdata[8] : 1'b0,
                                  sel:   wdata[EVT_SEL_W:1],
                                  en:    wdata[0]};
    end

    // R4
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count == $past(wdata));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_we) |-> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/evt_ctr_timer.sv
// Threshold timer: holds a threshold and raises a fixed-length pulse when the
// count first equals it. Assumes PULSE_W >= 1.
module evt_ctr_timer #(
    parameter int CTR_W   = 32,
    parameter int PULSE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTR_W-1:0] count,
    input  logic             thr_we,
    input  logic [CTR_W-1:0] wdata,
    output logic [CTR_W-1:0] thr,
    output logic             irq
);
    localparam int PC_W = $clog2(PULSE_W + 1);

    logic            match, match_q, fire;
    logic [PC_W-1:0] pulse_left;

    assign match = (count == thr);
    assign fire  = match && !match_q;
    assign irq   = (pulse_left != '0);

    // Threshold register; reset far from the reset count.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr <= '1;
        else if (thr_we) thr <= wdata;
    end

    // Edge detector on the match and pulse length counter (a new match restarts it).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q    <= 1'b0;
            pulse_left <= '0;
        end else begin
            match_q <= match;
            if (fire)                  pulse_left <= PC_W'(PULSE_W);
            else if (pulse_left != '0) pulse_left <= pulse_left - 1'b1;
        end
    end

    // R8
    fire_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq);

    // R8
    irq_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(fire)) |-> $past(irq));
endmodule

// File: rtl/evt_ctr_regif.sv
// Read side of the register port: registered read mux plus the shadow copies
// of high words for the pairs named in SHADOW_MASK (bit i set on even i).
module evt_ctr_regif import evt_ctr_pkg::*; #(
    parameter int          NUM_CTR     = 8,
    parameter int          CTR_W       = 32,
    parameter int          NUM_TMR     = 2,
    parameter logic [7:0]  SHADOW_MASK = 8'b0001_0100,
    parameter int          IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_kind_e        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [CTR_W-1:0] counts [NUM_CTR],
    input  ctr_cfg_t         cfgs   [NUM_CTR],
    input  logic [CTR_W-1:0] thrs   [NUM_TMR],
    output logic [CTR_W-1:0] rdata
);
    logic [CTR_W-1:0] shadow [NUM_CTR];
    logic [CTR_W-1:0] rd_val;
    logic [IDX_W-1:0] pair;

    // Shadow registers exist only on even counters with the feature.
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_sh
        if ((i % 2 == 0) && (i + 1 < NUM_CTR) && SHADOW_MASK[i]) begin : g_on
            // Capture the high word whenever software reads the chained low word.
            always_ff @(posedge clk) begin
                if (!rst_n) shadow[i] <= '0;
                else if (rd_en && kind == K_COUNT && 32'(idx) == i && cfgs[i].chain)
                    shadow[i] <= counts[i+1];
            end
        end else begin : g_off
            assign shadow[i] = '0;
        end
    end

    assign pair = {idx[IDX_W-1:1], 1'b0};

    // Select the read value for the addressed register.
    always_comb begin
        rd_val = '0;
        if (32'(idx) < NUM_CTR) begin
            case (kind)
                K_COUNT: begin
                    if (idx[0] && SHADOW_MASK[pair] && cfgs[pair].chain) rd_val = shadow[pair];
                    else                                                 rd_val = counts[idx];
                end
                K_CFG:   rd_val = CTR_W'({cfgs[idx].chain, 2'b00, cfgs[idx].sel, cfgs[idx].en});
                K_THR:   if (32'(idx) < NUM_TMR) rd_val = thrs[idx];
                default: rd_val = '0;
            endcase
        end
    end

    // Read data register: updated on a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/evt_ctr_bank.sv
// Top of the event counter bank: decodes register writes, wires the carry
// between paired counters and attaches timers to the first NUM_TMR counters.
// Assumes NUM_CTR is a power of two and NUM_TMR >= 1.
module evt_ctr_bank import evt_ctr_pkg::*; #(
    parameter int         NUM_CTR     = 8,
    parameter int         CTR_W       = 32,
    parameter int         NUM_EVT     = 31,
    parameter int         NUM_TMR     = 2,
    parameter int         PULSE_W     = 2,
    parameter logic [7:0] SHADOW_MASK = 8'b0001_0100,
    localparam int        IDX_W       = $clog2(NUM_CTR),
    localparam int        ADDR_W      = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CTR_W-1:0]   reg_wdata,
    output logic [CTR_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [NUM_TMR-1:0] tmr_irq
);
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic [CTR_W-1:0] counts [NUM_CTR];
    ctr_cfg_t         cfgs   [NUM_CTR];
    logic             wraps  [NUM_CTR];
    logic             cnt_we [NUM_CTR];
    logic [CTR_W-1:0] thrs   [NUM_TMR];

    assign kind = reg_kind_e'(reg_addr[ADDR_W-1:IDX_W]);
    assign idx  = reg_addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic use_c, cin, cfg_we;
        if (i % 2 == 1) begin : g_odd
            assign use_c = cfgs[i-1].chain;
            assign cin   = wraps[i-1];
        end else begin : g_even
            assign use_c = 1'b0;
            assign cin   = 1'b0;
        end
        assign cnt_we[i] = reg_wr && kind == K_COUNT && 32'(idx) == i;
        assign cfg_we    = reg_wr && kind == K_CFG   && 32'(idx) == i;

        evt_ctr_cell #(
            .CTR_W     (CTR_W),
            .NUM_EVT   (NUM_EVT),
            .CAN_CHAIN ((i % 2 == 0) && (i + 1 < NUM_CTR))
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_we    (cnt_we[i]),
            .cfg_we    (cfg_we),
            .wdata     (reg_wdata),
            .evt       (evt_in),
            .use_carry (use_c),
            .carry_in  (cin),
            .count     (counts[i]),
            .cfg       (cfgs[i]),
            .wrap      (wraps[i])
        );

        if ((i % 2 == 1)) begin : g_chk
            // R5
            chain_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(cfgs[i-1].chain) && !$past(cnt_we[i]) && (counts[i] != $past(counts[i])))
                |-> ($past(counts[i-1]) == '1) && (counts[i-1] == '0));
        end
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic thr_we;
        assign thr_we = reg_wr && kind == K_THR && 32'(idx) == t;

        evt_ctr_timer #(
            .CTR_W   (CTR_W),
            .PULSE_W (PULSE_W)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .count  (counts[t]),
            .thr_we (thr_we),
            .wdata  (reg_wdata),
            .thr    (thrs[t]),
            .irq    (tmr_irq[t])
        );
    end

    evt_ctr_regif #(
        .NUM_CTR     (NUM_CTR),
        .CTR_W       (CTR_W),
        .NUM_TMR     (NUM_TMR),
        .SHADOW_MASK (SHADOW_MASK),
        .IDX_W       (IDX_W)
    ) u_regif (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (reg_rd),
        .kind   (kind),
        .idx    (idx),
        .counts (counts),
        .cfgs   (cfgs),
        .thrs   (thrs),
        .rdata  (reg_rdata)
    );
endmodule

// File: tb/tb_evt_ctr_bank.sv
// Bench: behavioural model updated at every rising edge, compared at every
// falling edge, plus directed scenarios with explicit expected values.
module tb_evt_ctr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [30:0] evt_in = '0;
    logic [1:0]  tmr_irq;

    int total = 0, fails = 0, cyc = 0, hi_cnt = 0;
    string phase = "R1";
    bit started = 0, finished = 0;

    always #4 clk = ~clk;

    evt_ctr_bank dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .tmr_irq(tmr_irq));

    // ---------------- behavioural model ----------------
    logic [31:0] m_cnt [8];
    logic [31:0] m_sh  [8];
    logic [31:0] m_thr [2];
    logic [31:0] m_rdata;
    bit          m_en [8];
    bit          m_ch [8];
    int          m_sel [8];
    bit          m_mq [2];
    int          m_pc [2];

    always @(posedge clk) begin
        int  k, ix;
        bit  stp [8];
        bit  wrp [8];
        k  = int'(reg_addr[4:3]);
        ix = int'(reg_addr[2:0]);
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_cnt[i] = 0; m_sh[i] = 0; m_en[i] = 0; m_ch[i] = 0; m_sel[i] = 0;
            end
            for (int t = 0; t < 2; t++) begin m_thr[t] = '1; m_mq[t] = 0; m_pc[t] = 0; end
            m_rdata = 0;
            started = 1;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (i % 2 == 1 && m_ch[i-1]) stp[i] = wrp[i-1];
                else stp[i] = m_en[i] && m_sel[i] < 31 && evt_in[m_sel[i]];
                wrp[i] = stp[i] && m_cnt[i] == 32'hFFFF_FFFF && !(reg_wr && k == 0 && ix == i);
            end
            if (reg_rd) begin
                case (k)
                    0: begin
                        if (ix % 2 == 1 && (ix == 3 || ix == 5) && m_ch[ix-1]) m_rdata = m_sh[ix-1];
                        else m_rdata = m_cnt[ix];
                        if ((ix == 2 || ix == 4) && m_ch[ix]) m_sh[ix] = m_cnt[ix+1];
                    end
                    1: m_rdata = (32'(m_ch[ix]) << 8) | (32'(m_sel[ix]) << 1) | 32'(m_en[ix]);
                    2: m_rdata = (ix < 2) ? m_thr[ix] : 0;
                    default: m_rdata = 0;
                endcase
            end
            for (int t = 0; t < 2; t++) begin
                bit mt;
                mt = (m_cnt[t] == m_thr[t]);
                if (mt && !m_mq[t]) m_pc[t] = 2;
                else if (m_pc[t] > 0) m_pc[t] = m_pc[t] - 1;
                m_mq[t] = mt;
            end
            for (int i = 0; i < 8; i++) begin
                if (reg_wr && k == 0 && ix == i) m_cnt[i] = reg_wdata;
                else if (stp[i]) m_cnt[i] = m_cnt[i] + 1;
            end
            if (reg_wr && k == 1) begin
                m_en[ix] = reg_wdata[0];
                m_sel[ix] = int'(reg_wdata[5:1]);
                m_ch[ix] = (ix % 2 == 0) ? reg_wdata[8] : 1'b0;
            end
            if (reg_wr && k == 2 && ix < 2) m_thr[ix] = reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            check(phase, reg_rdata, m_rdata);
            check("R8", {30'd0, tmr_irq}, {30'd0, m_pc[1] != 0, m_pc[0] != 0});
            if (tmr_irq[1]) hi_cnt++;
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            summary();
        end
    end

    function automatic logic [4:0] ad(input int k, input int i);
        return 5'(k * 8 + i);
    endfunction

    function automatic logic [31:0] cf(input bit ch, input int sel, input bit en);
        return (32'(ch) << 8) | (32'(sel) << 1) | 32'(en);
    endfunction

    // Called and returns at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        phase = "R1";
        rd(ad(0, 0), v); check("R1 count0", v, 0);
        rd(ad(1, 3), v); check("R1 cfg3", v, 0);
        rd(ad(2, 0), v); check("R1 thr0", v, 32'hFFFF_FFFF);
        check("R1 irq", {30'd0, tmr_irq}, 0);

        // R3 counting, select 31 and disabled counters stay
        phase = "R3";
        wr(ad(1, 5), cf(0, 4, 1));
        wr(ad(1, 6), cf(0, 31, 1));
        wr(ad(1, 7), cf(0, 4, 0));
        evt_in = '1;
        repeat (10) @(negedge clk);
        evt_in = '0;
        rd(ad(0, 5), v); check("R3 count5", v, 10);
        rd(ad(0, 6), v); check("R3 count6 sel31", v, 0);
        rd(ad(0, 7), v); check("R3 count7 disabled", v, 0);

        // R2 configuration readback, kind 3, hold of read data
        phase = "R2";
        rd(ad(1, 5), v); check("R2 cfg5", v, 32'h9);
        evt_in[4] = 1;
        repeat (3) @(negedge clk);
        check("R2 rdata held", reg_rdata, 32'h9);
        rd(ad(3, 1), v); check("R2 kind3", v, 0);

        // R4 write beats an increment in the same cycle
        phase = "R4";
        wr(ad(0, 5), 100);
        evt_in = '0;
        rd(ad(0, 5), v); check("R4 count5", v, 100);

        // R5 chain 0/1, odd select ignored
        phase = "R5";
        wr(ad(1, 1), cf(0, 4, 1));
        wr(ad(1, 0), cf(1, 4, 1));
        wr(ad(0, 0), 32'hFFFF_FFFD);
        wr(ad(0, 1), 5);
        evt_in[4] = 1;
        repeat (5) @(negedge clk);
        evt_in = '0;
        rd(ad(0, 0), v); check("R5 low word", v, 2);
        rd(ad(0, 1), v); check("R5 high word", v, 6);
        rd(ad(1, 1), v); check("R5 odd chain bit", v, cf(0, 4, 1));

        // R6 shadow on pair 2/3
        phase = "R6";
        wr(ad(1, 2), cf(1, 7, 1));
        wr(ad(0, 2), 32'hFFFF_FFFE);
        wr(ad(0, 3), 32'h33);
        rd(ad(0, 2), v); check("R6 low", v, 32'hFFFF_FFFE);
        evt_in[7] = 1;
        repeat (3) @(negedge clk);
        evt_in = '0;
        rd(ad(0, 3), v); check("R6 shadow high", v, 32'h33);
        rd(ad(0, 2), v); check("R6 low after wrap", v, 1);
        rd(ad(0, 3), v); check("R6 new shadow", v, 32'h34);

        // R7 pair 6/7 has no shadow
        phase = "R7";
        wr(ad(1, 6), cf(1, 7, 1));
        wr(ad(0, 6), 32'hFFFF_FFFF);
        wr(ad(0, 7), 9);
        rd(ad(0, 6), v); check("R7 low", v, 32'hFFFF_FFFF);
        evt_in[7] = 1;
        @(negedge clk);
        evt_in = '0;
        rd(ad(0, 7), v); check("R7 live high", v, 10);

        // R8 timer 1 pulse length
        phase = "R8";
        wr(ad(1, 0), 0);
        wr(ad(1, 1), cf(0, 9, 1));
        wr(ad(0, 1), 0);
        wr(ad(2, 1), 5);
        repeat (3) @(negedge clk);
        hi_cnt = 0;
        evt_in[9] = 1;
        repeat (10) @(negedge clk);
        evt_in = '0;
        repeat (4) @(negedge clk);
        check("R8 pulse cycles", 32'(hi_cnt), 2);

        // R9 no re-trigger while equal
        phase = "R9";
        wr(ad(1, 1), 0);
        wr(ad(2, 1), 20);
        repeat (4) @(negedge clk);
        hi_cnt = 0;
        wr(ad(0, 1), 20);
        repeat (8) @(negedge clk);
        check("R9 single pulse", 32'(hi_cnt), 2);
        // R9 restart during a pulse
        wr(ad(0, 1), 7);
        repeat (4) @(negedge clk);
        hi_cnt = 0;
        wr(ad(0, 1), 20);
        wr(ad(0, 1), 21);
        wr(ad(0, 1), 20);
        repeat (8) @(negedge clk);
        check("R9 restarted pulse", 32'(hi_cnt), 4);

        // R10 thresholds without a timer
        phase = "R10";
        wr(ad(2, 5), 32'h1234);
        rd(ad(2, 5), v); check("R10 thr5", v, 0);
        rd(ad(2, 1), v); check("R10 thr1 intact", v, 20);

        repeat (2) @(negedge clk);
        summary();
    end
endmodule